// File: doc/BRIEF.md
# FPU Stage Reservation Scoreboard

This block keeps a forward-looking occupancy table for the four stages of a floating-point pipeline (named F0 to F3 here) and for two multiplier slots, M0 and M1, that may overlap each other. Each request names an operation class. Every class claims a fixed set of resources in each cycle after it is accepted. The block compares that per-cycle claim with what is already booked. It raises ready only when no cycle collides. On acceptance it books the claim into the table.

The table advances by one cycle on every clock. The entry at the head gives the occupancy of the current cycle, and that entry is driven on `busy_o` for observation. A request that collides waits with valid held and is granted on the first cycle in which it fits. The two multiplier slots are exclusive with F1. In the middle part of a multiply, each cycle takes whichever slot is free, so two multiplies can overlap.

Top module: `fpu_rsv_scoreboard`

## Requirements
- R1: `busy_o` shows the bookings for the current cycle, with bit 0 = F0, bit 1 = F1, bit 2 = F2, bit 3 = F3, bit 4 = M0 and bit 5 = M1. Offset k of a pattern lands in the k-th cycle after the clock edge that accepts the request.
- R2: Class code 0 (single-precision arithmetic) books F0+F1 at offset 1 and F2 at offset 2.
- R3: Class code 1 (single-precision divide) books F0+F1+F3 at offset 1, F2+F3 at 2, F3 alone at 3 to 9, F1+F3 at 10 and F2 at 11.
- R4: Class code 2 (double-precision add/multiply) books F0+F1 at offset 1, F1+F2 at 2 to 6 and F2 at 7.
- R5: Class code 3 (double-precision divide) books F0+F1+F3 at offset 1, F1+F2+F3 at 2, F2+F3 at 3, F3 alone at 4 to 19, F1+F3 at 20, F1+F2+F3 at 21 and 22, and F2 at 23.
- R6: Class code 4 (double-precision convert) books F0+F1 at offset 1, F1+F2 at 2 and F2 at 3.
- R7: Class code 5 (integer multiply) books M0 at offset 1 and one multiplier slot at each of offsets 2 to 4. In those cycles it takes M1 when M1 is free and M0 otherwise. It books F2 at offset 5. No cycle ever holds F1 together with M0 or M1.
- R8: Class code 6 (status/control register load) books F1 at offsets 2, 3 and 4. Class code 7 books nothing and is always ready.
- R9: `req_ready_o` is high exactly when the presented class collides in no cycle. A request that is not accepted leaves the bookings untouched, and the table only shifts.
- R10: A synchronous active-low reset clears every booking. After reset, `busy_o` is 0 and every class is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_class_i | input | 3 | Operation class code |
| req_ready_o | output | 1 | Request fits and is accepted when valid |
| busy_o | output | 6 | Resources booked in the current cycle |

## Verification
The critical overlap is a new booking being merged in the same clock as the table shifts out its head entry. An off-by-one in either path moves a whole pattern by a cycle. The bench provokes this by holding a colliding request through a sweep of start delays: divide after divide, multiply after status load, and add after double divide. It checks that ready rises at exactly the first delay derived from the patterns, and that `busy_o` keeps the first operation's shape while the request waits. A second overlap, between the two multiplier slots, is judged by issuing two multiplies one cycle apart and comparing the combined occupancy cycle by cycle.

// File: rtl/fpu_rsv_pkg.sv
// Package: resource bit positions, operation class codes and the per-class
// booking patterns of the FPU reservation scoreboard.
// Assumes offset 0 is the acceptance cycle itself, which books nothing.
package fpu_rsv_pkg;

    localparam int RES_W     = 6;
    localparam int B_F0      = 0;
    localparam int B_F1      = 1;
    localparam int B_F2      = 2;
    localparam int B_F3      = 3;
    localparam int B_M0      = 4;
    localparam int B_M1      = 5;
    localparam int MIN_DEPTH = 24;

    typedef logic [RES_W-1:0] rmask_t;

    localparam rmask_t MK_F0 = rmask_t'(1) << B_F0;
    localparam rmask_t MK_F1 = rmask_t'(1) << B_F1;
    localparam rmask_t MK_F2 = rmask_t'(1) << B_F2;
    localparam rmask_t MK_F3 = rmask_t'(1) << B_F3;
    localparam rmask_t MK_M0 = rmask_t'(1) << B_M0;
    localparam rmask_t MK_M1 = rmask_t'(1) << B_M1;

    typedef enum logic [2:0] {
        CLS_SP_ARITH  = 3'd0,
        CLS_SP_DIV    = 3'd1,
        CLS_DP_ARITH  = 3'd2,
        CLS_DP_DIV    = 3'd3,
        CLS_DP_CONV   = 3'd4,
        CLS_MUL       = 3'd5,
        CLS_CTRL_LOAD = 3'd6,
        CLS_NOP       = 3'd7
    } op_cls_e;

    // Fixed resources a class books at offset k (flexible multiplier slots excluded).
    function automatic rmask_t fixed_mask(op_cls_e c, int k);
        rmask_t m;
        m = '0;
        unique case (c)
            CLS_SP_ARITH: begin
                if (k == 1) m = MK_F0 | MK_F1;
                if (k == 2) m = MK_F2;
            end
            CLS_SP_DIV: begin
                if (k >= 1 && k <= 10) m = MK_F3;
                if (k == 1)  m = m | MK_F0 | MK_F1;
                if (k == 2)  m = m | MK_F2;
                if (k == 10) m = m | MK_F1;
                if (k == 11) m = MK_F2;
            end
            CLS_DP_ARITH: begin
                if (k == 1) m = MK_F0 | MK_F1;
                if (k >= 2 && k <= 6) m = MK_F1 | MK_F2;
                if (k == 7) m = MK_F2;
            end
            CLS_DP_DIV: begin
                if (k >= 1 && k <= 22) m = MK_F3;
                if (k == 1) m = m | MK_F0 | MK_F1;
                if (k == 2 || k == 21 || k == 22) m = m | MK_F1 | MK_F2;
                if (k == 3) m = m | MK_F2;
                if (k == 20) m = m | MK_F1;
                if (k == 23) m = MK_F2;
            end
            CLS_DP_CONV: begin
                if (k == 1) m = MK_F0 | MK_F1;
                if (k == 2) m = MK_F1 | MK_F2;
                if (k == 3) m = MK_F2;
            end
            CLS_MUL: begin
                if (k == 1) m = MK_M0;
                if (k == 5) m = MK_F2;
            end
            CLS_CTRL_LOAD: begin
                if (k >= 2 && k <= 4) m = MK_F1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

    // True where a class needs one multiplier slot, either one.
    function automatic logic flex_slot(op_cls_e c, int k);
        return (c == CLS_MUL) && (k >= 2) && (k <= 4);
    endfunction

endpackage

// File: rtl/fpu_rsv_pattern.sv
// Expands an operation class into per-offset fixed masks and flexible
// multiplier-slot flags, one pair per table row.
// Assumes DEPTH rows cover the longest pattern.
module fpu_rsv_pattern
    import fpu_rsv_pkg::*;
#(
    parameter int DEPTH = MIN_DEPTH
) (
    input  op_cls_e                       cls_i,
    output logic [DEPTH-1:0][RES_W-1:0]   fix_o,
    output logic [DEPTH-1:0]              flex_o
);

    // One row of the pattern per offset.
    for (genvar k = 0; k < DEPTH; k++) begin : g_row
        assign fix_o[k]  = fixed_mask(cls_i, k);
        assign flex_o[k] = flex_slot(cls_i, k);
    end

endmodule

// File: rtl/fpu_rsv_check.sv
// Compares a candidate pattern against the booked table, row by row, and
// resolves each flexible multiplier need to a concrete slot (M1 first).
// Assumes row k of both inputs refers to the same future cycle.
module fpu_rsv_check
    import fpu_rsv_pkg::*;
#(
    parameter int DEPTH = MIN_DEPTH
) (
    input  logic [DEPTH-1:0][RES_W-1:0]   tab_i,
    input  logic [DEPTH-1:0][RES_W-1:0]   fix_i,
    input  logic [DEPTH-1:0]              flex_i,
    output logic                          clash_o,
    output logic [DEPTH-1:0][RES_W-1:0]   res_o
);

    logic [DEPTH-1:0] clash_v;

    // Per-row collision test and slot choice.
    for (genvar k = 0; k < DEPTH; k++) begin : g_row
        logic need_mul;
        logic same_res;
        logic f1_vs_mul;
        logic mul_vs_f1;
        logic no_slot;
        assign need_mul  = fix_i[k][B_M0] | fix_i[k][B_M1] | flex_i[k];
        assign same_res  = |(fix_i[k] & tab_i[k]);
        assign f1_vs_mul = fix_i[k][B_F1] & (tab_i[k][B_M0] | tab_i[k][B_M1]);
        assign mul_vs_f1 = need_mul & tab_i[k][B_F1];
        assign no_slot   = flex_i[k] & tab_i[k][B_M0] & tab_i[k][B_M1];
        assign clash_v[k] = same_res | f1_vs_mul | mul_vs_f1 | no_slot;
        assign res_o[k]   = fix_i[k] |
                            (flex_i[k] ? (tab_i[k][B_M1] ? MK_M0 : MK_M1) : '0);
    end

    assign clash_o = |clash_v;

endmodule

// File: rtl/fpu_rsv_table.sv
// Shift register of future-cycle resource bookings. Row 0 is the current
// cycle; each clock every row moves one step toward row 0 and an accepted
// pattern is merged at the same time (its row k lands in row k-1).
// Assumes the merged pattern was checked free of collisions.
module fpu_rsv_table
    import fpu_rsv_pkg::*;
#(
    parameter int DEPTH = MIN_DEPTH
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          merge_en,
    input  logic [DEPTH-1:0][RES_W-1:0]   res_i,
    output logic [DEPTH-1:0][RES_W-1:0]   tab_o
);

    logic [DEPTH-1:0][RES_W-1:0] nxt;

    // Next table: shifted bookings plus the shifted new pattern.
    always_comb begin
        nxt = (tab_o >> RES_W) | (merge_en ? (res_i >> RES_W) : '0);
    end

    // Table register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) tab_o <= '0;
        else        tab_o <= nxt;
    end

    AST_MUL_F1_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tab_o[0][B_F1] && (tab_o[0][B_M0] || tab_o[0][B_M1]))); // R7

    AST_IDLE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !merge_en |=> tab_o[0] == $past(tab_o[1])); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> tab_o == '0); // R10

endmodule

// File: rtl/fpu_rsv_scoreboard.sv
// Top of the FPU reservation scoreboard: expands the requested class,
// checks it against the bookings, grants ready when it fits and books it.
// Assumes the requester holds valid and class stable until ready.
module fpu_rsv_scoreboard
    import fpu_rsv_pkg::*;
#(
    parameter int DEPTH = MIN_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    input  logic [2:0]           req_class_i,
    output logic                 req_ready_o,
    output logic [RES_W-1:0]     busy_o
);

    if (DEPTH < MIN_DEPTH) begin : g_depth_bad
        $error("DEPTH too small for the longest pattern");
    end

    op_cls_e                     cls;
    logic [DEPTH-1:0][RES_W-1:0] fix;
    logic [DEPTH-1:0]            flex;
    logic [DEPTH-1:0][RES_W-1:0] res;
    logic [DEPTH-1:0][RES_W-1:0] tab;
    logic                        clash;
    logic                        accept;

    assign cls = op_cls_e'(req_class_i);

    fpu_rsv_pattern #(.DEPTH(DEPTH)) u_pattern (
        .cls_i  (cls),
        .fix_o  (fix),
        .flex_o (flex)
    );

    fpu_rsv_check #(.DEPTH(DEPTH)) u_check (
        .tab_i   (tab),
        .fix_i   (fix),
        .flex_i  (flex),
        .clash_o (clash),
        .res_o   (res)
    );

    // Grant only outside reset and when no row collides.
    assign req_ready_o = rst_n & ~clash;
    assign accept      = req_valid_i & req_ready_o;

    fpu_rsv_table #(.DEPTH(DEPTH)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .merge_en (accept),
        .res_i    (res),
        .tab_o    (tab)
    );

    assign busy_o = tab[0];

    AST_SP_ARITH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cls == CLS_SP_ARITH |=> busy_o[B_F0] && busy_o[B_F1]); // R2

    AST_DIV_HOLDS_F3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cls == CLS_SP_DIV |=> busy_o[B_F3]); // R3

    AST_NOP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cls == CLS_NOP |-> req_ready_o); // R8

endmodule

// File: tb/fpu_rsv_scoreboard_tb.sv
module fpu_rsv_scoreboard_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_class = 3'd0;
    logic       req_ready;
    logic [5:0] busy;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    fpu_rsv_scoreboard u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_class_i (req_class),
        .req_ready_o (req_ready),
        .busy_o      (busy)
    );

    // Expected bookings of one class alone at offset k (bit0 F0 .. bit5 M1).
    function automatic logic [5:0] exp_mask(int c, int k);
        case (c)
            0: return (k == 1) ? 6'h03 : (k == 2) ? 6'h04 : 6'h00;
            1: begin
                if (k == 1) return 6'h0B;
                if (k == 2) return 6'h0C;
                if (k >= 3 && k <= 9) return 6'h08;
                if (k == 10) return 6'h0A;
                if (k == 11) return 6'h04;
                return 6'h00;
            end
            2: begin
                if (k == 1) return 6'h03;
                if (k >= 2 && k <= 6) return 6'h06;
                if (k == 7) return 6'h04;
                return 6'h00;
            end
            3: begin
                if (k == 1) return 6'h0B;
                if (k == 2) return 6'h0E;
                if (k == 3) return 6'h0C;
                if (k >= 4 && k <= 19) return 6'h08;
                if (k == 20) return 6'h0A;
                if (k == 21 || k == 22) return 6'h0E;
                if (k == 23) return 6'h04;
                return 6'h00;
            end
            4: return (k == 1) ? 6'h03 : (k == 2) ? 6'h06 : (k == 3) ? 6'h04 : 6'h00;
            5: begin
                if (k == 1) return 6'h10;
                if (k >= 2 && k <= 4) return 6'h20;
                if (k == 5) return 6'h04;
                return 6'h00;
            end
            6: return (k >= 2 && k <= 4) ? 6'h02 : 6'h00;
            default: return 6'h00;
        endcase
    endfunction

    task automatic chk(input int act, input int expv, input string tag, input string what);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // One class alone from an empty table; compare every cycle of its pattern.
    task automatic solo(input int c, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_class = c[2:0];
        #1 chk(int'(req_ready), 1, tag, "ready on empty table");
        for (int k = 1; k <= 25; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            #1 chk(int'(busy), int'(exp_mask(c, k)), tag, $sformatf("busy offset %0d", k));
        end
    endtask

    // First class accepted, second held; ready must rise exactly at delay thr.
    task automatic sweep(input int first, input int second, input int thr, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_class = first[2:0];
        #1 chk(int'(req_ready), 1, tag, "first ready");
        for (int d = 1; d <= thr; d++) begin
            @(negedge clk);
            req_class = second[2:0];
            #1;
            chk(int'(req_ready), (d >= thr) ? 1 : 0, tag, $sformatf("ready at delay %0d", d));
            chk(int'(busy), int'(exp_mask(first, d)), "R9", $sformatf("busy unchanged while waiting %0d", d));
        end
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(int'(busy), 0, "R10", "busy in reset");
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(int'(busy), 0, "R10", "busy after reset");
        chk(int'(req_ready), 1, "R10", "ready after reset");

        solo(0, "R2");
        solo(1, "R3");
        solo(2, "R4");
        solo(3, "R5");
        solo(4, "R6");
        solo(5, "R7");
        solo(6, "R8");
        solo(7, "R8");
        solo(0, "R1");

        sweep(1, 1, 10, "R3");
        sweep(6, 5, 4, "R7");
        sweep(3, 0, 2, "R9");
        sweep(0, 0, 1, "R2");

        // Two multiplies one cycle apart share M0/M1 (R7).
        @(negedge clk);
        req_valid = 1'b1;
        req_class = 3'd5;
        @(negedge clk);
        #1;
        chk(int'(req_ready), 1, "R7", "second multiply ready");
        chk(int'(busy), 'h10, "R7", "mul overlap c+1");
        @(negedge clk);
        req_valid = 1'b0;
        #1 chk(int'(busy), 'h30, "R7", "mul overlap c+2");
        @(negedge clk); #1 chk(int'(busy), 'h30, "R7", "mul overlap c+3");
        @(negedge clk); #1 chk(int'(busy), 'h30, "R7", "mul overlap c+4");
        @(negedge clk); #1 chk(int'(busy), 'h24, "R7", "mul overlap c+5");
        @(negedge clk); #1 chk(int'(busy), 'h04, "R7", "mul overlap c+6");
        @(negedge clk); #1 chk(int'(busy), 'h00, "R7", "mul overlap c+7");

        // Reset in the middle of a long divide clears everything (R10).
        @(negedge clk);
        req_valid = 1'b1;
        req_class = 3'd3;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(int'(busy), 0, "R10", "busy after mid-flight reset");
        chk(int'(req_ready), 1, "R10", "ready after mid-flight reset");
        @(negedge clk);
        #1 chk(int'(busy), 0, "R10", "no stale booking after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule